// File: doc/BRIEF.md
# Rectangle Raster Compositor

This block colours every pixel of a 640x480 screen from a list of up to 64 axis-aligned rectangles. It keeps no framebuffer. During blanking, a loader writes each rectangle's four bounds and its colour. For every screen column, the block keeps a 64-bit mask of the rectangles that span that column. It keeps the same kind of mask for every screen row. Each load updates one bit position in every one of these masks in a single cycle.

During display, the pixel position selects one column mask and one row mask. Their bitwise AND is the set of rectangles that cover the pixel. A pipelined tree of 2:1 selectors reduces that set to a single winning index, and the winner's colour is driven out. The data-enable strobe travels down a matching delay line, so the output stays aligned with the coordinates that produced it. A frame-clear pulse, issued once per frame before reloading, empties every mask.

Top module: `rect_raster`

## Requirements
- R1: After reset, `rgb_out` is 0 and `de_out` is 0. No rectangle covers any pixel, so a displayed pixel shows `bg_colour`.
- R2: Rectangle n covers pixel (x,y) exactly when left <= x < right and top <= y < bottom. The lower bounds are inclusive and the upper bounds are exclusive.
- R3: When several rectangles cover a pixel, the colour of the one with the largest index is shown.
- R4: A displayed pixel that no rectangle covers shows `bg_colour`.
- R5: A rectangle with left >= right, or with top >= bottom, covers no pixel.
- R6: Loading index n again replaces both its earlier bounds and its colour. Pixels inside only the old area no longer show it.
- R7: A `frame_clear` pulse empties every column and row mask. If a load arrives in the same cycle as the clear, that rectangle is kept.
- R8: `rgb_out` and `de_out` follow `pix_x`, `pix_y` and `pix_de` by exactly 8 clock cycles.
- R9: While `de_out` is 0, `rgb_out` is 0.
- R10: A pixel at x >= 640 or y >= 480 is covered by no rectangle, even when its bounds reach past the screen. Such a pixel shows `bg_colour`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clear | input | 1 | Empty all coverage masks at this edge |
| ld_en | input | 1 | Load one rectangle at this edge |
| ld_idx | input | 6 | Index of the rectangle being loaded |
| ld_left | input | 10 | First covered column (inclusive) |
| ld_right | input | 10 | Column just past the rectangle (exclusive) |
| ld_top | input | 10 | First covered row (inclusive) |
| ld_bottom | input | 10 | Row just past the rectangle (exclusive) |
| ld_colour | input | 16 | Colour of the rectangle |
| bg_colour | input | 16 | Colour for pixels that no rectangle covers |
| pix_x | input | 10 | Current pixel column |
| pix_y | input | 10 | Current pixel row |
| pix_de | input | 1 | Current pixel lies in the visible area |
| rgb_out | output | 16 | Pixel colour, 8 cycles after the coordinates |
| de_out | output | 1 | `pix_de` delayed by 8 cycles |

## Verification
The assertions check the time-invariant properties on every cycle:
- blanking forces the colour to zero;
- the enable strobe arrives exactly eight cycles after its input;
- the state after reset is correct;
- once a clear has settled with no load since, every displayed pixel carries the background colour.

Coverage geometry can only be shown by the bench's scenarios, which probe chosen pixels against a known scene. These include the inclusive and exclusive edges, overlap priority, empty rectangles, off-screen coordinates, replacement on reload, and a load in the same cycle as a clear.

// File: rtl/rr_pkg.sv
package rr_pkg;
    // Default geometry of the raster and of the rectangle list
    parameter int RR_RECTS  = 64;
    parameter int RR_COLS   = 640;
    parameter int RR_ROWS   = 480;
    parameter int RR_COORDW = 10;
    parameter int RR_COLW   = 16;

    // Pipeline registers: hit capture, one per tree level, colour stage
    function automatic int rr_latency(input int rects);
        return $clog2(rects) + 2;
    endfunction
endpackage

// File: rtl/rr_mask_store.sv
module rr_mask_store
    import rr_pkg::*;
#(
    parameter int N      = RR_RECTS,
    parameter int COLS   = RR_COLS,
    parameter int ROWS   = RR_ROWS,
    parameter int CW     = RR_COORDW,
    localparam int IDXW  = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            ld_en,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [CW-1:0]   ld_left,
    input  logic [CW-1:0]   ld_right,
    input  logic [CW-1:0]   ld_top,
    input  logic [CW-1:0]   ld_bottom,
    input  logic [CW-1:0]   pix_x,
    input  logic [CW-1:0]   pix_y,
    input  logic            pix_de,
    output logic [N-1:0]    hit,
    output logic            hit_de
);
    localparam logic [CW-1:0] COL_LIM = CW'(COLS);
    localparam logic [CW-1:0] ROW_LIM = CW'(ROWS);

    typedef struct packed {
        logic [N-1:0] hit;
        logic         de;
    } probe_t;

    logic [N-1:0] col_d [COLS];
    logic [N-1:0] col_q [COLS];
    logic [N-1:0] row_d [ROWS];
    logic [N-1:0] row_q [ROWS];
    probe_t       pr_d, pr_q;

    // Next state of the coverage masks: clear first, then apply the load
    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            col_d[c] = clear ? '0 : col_q[c];
            if (ld_en)
                col_d[c][ld_idx] = (CW'(c) >= ld_left) && (CW'(c) < ld_right);
        end
        for (int r = 0; r < ROWS; r++) begin
            row_d[r] = clear ? '0 : row_q[r];
            if (ld_en)
                row_d[r][ld_idx] = (CW'(r) >= ld_top) && (CW'(r) < ld_bottom);
        end
    end

    // Per-pixel hit vector: column mask AND row mask
    always_comb begin
        pr_d.de  = pix_de;
        pr_d.hit = '0;
        if ((pix_x < COL_LIM) && (pix_y < ROW_LIM))
            pr_d.hit = col_q[pix_x] & row_q[pix_y];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < COLS; c++) col_q[c] <= '0;
            for (int r = 0; r < ROWS; r++) row_q[r] <= '0;
            pr_q <= '0;
        end else begin
            for (int c = 0; c < COLS; c++) col_q[c] <= col_d[c];
            for (int r = 0; r < ROWS; r++) row_q[r] <= row_d[r];
            pr_q <= pr_d;
        end
    end

    assign hit    = pr_q.hit;
    assign hit_de = pr_q.de;
endmodule

// File: rtl/rr_pick_tree.sv
module rr_pick_tree
    import rr_pkg::*;
#(
    parameter int N      = RR_RECTS,
    localparam int IDXW  = $clog2(N),
    localparam int LVLS  = IDXW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    hit,
    input  logic            de_in,
    output logic            win_valid,
    output logic [IDXW-1:0] win_idx,
    output logic            de_out
);
    typedef struct packed {
        logic            v;
        logic [IDXW-1:0] idx;
    } node_t;

    // Heap layout: node j has children 2j and 2j+1; positions N..2N-1 are leaves
    node_t           node_d [N];
    node_t           node_q [N];
    logic [LVLS-1:0] de_d, de_q;

    always_comb begin
        node_t lo, hi;
        node_d[0] = '0;
        for (int j = 1; j < N; j++) begin
            if (2 * j >= N) begin
                lo.v   = hit[IDXW'(2 * j - N)];
                lo.idx = IDXW'(2 * j - N);
                hi.v   = hit[IDXW'(2 * j + 1 - N)];
                hi.idx = IDXW'(2 * j + 1 - N);
            end else begin
                lo = node_q[IDXW'(2 * j)];
                hi = node_q[IDXW'(2 * j + 1)];
            end
            // higher index wins when it is present
            node_d[j] = hi.v ? hi : lo;
        end
        de_d = {de_q[LVLS-2:0], de_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) node_q[j] <= '0;
            de_q <= '0;
        end else begin
            for (int j = 0; j < N; j++) node_q[j] <= node_d[j];
            de_q <= de_d;
        end
    end

    assign win_valid = node_q[1].v;
    assign win_idx   = node_q[1].idx;
    assign de_out    = de_q[LVLS-1];
endmodule

// File: rtl/rr_colour_out.sv
module rr_colour_out
    import rr_pkg::*;
#(
    parameter int N      = RR_RECTS,
    parameter int COLW   = RR_COLW,
    localparam int IDXW  = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [COLW-1:0] ld_colour,
    input  logic [COLW-1:0] bg_colour,
    input  logic            win_valid,
    input  logic [IDXW-1:0] win_idx,
    input  logic            win_de,
    output logic [COLW-1:0] rgb,
    output logic            de
);
    typedef struct packed {
        logic [COLW-1:0] rgb;
        logic            de;
    } pix_t;

    logic [COLW-1:0] pal_d [N];
    logic [COLW-1:0] pal_q [N];
    pix_t            px_d, px_q;

    always_comb begin
        for (int i = 0; i < N; i++) pal_d[i] = pal_q[i];
        if (ld_en) pal_d[ld_idx] = ld_colour;

        px_d.de = win_de;
        if (!win_de)
            px_d.rgb = '0;
        else if (win_valid)
            px_d.rgb = pal_q[win_idx];
        else
            px_d.rgb = bg_colour;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) pal_q[i] <= '0;
            px_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) pal_q[i] <= pal_d[i];
            px_q <= px_d;
        end
    end

    assign rgb = px_q.rgb;
    assign de  = px_q.de;
endmodule

// File: rtl/rect_raster.sv
module rect_raster
    import rr_pkg::*;
#(
    parameter int N      = RR_RECTS,
    parameter int COLS   = RR_COLS,
    parameter int ROWS   = RR_ROWS,
    parameter int CW     = RR_COORDW,
    parameter int COLW   = RR_COLW,
    localparam int IDXW  = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_clear,
    input  logic            ld_en,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [CW-1:0]   ld_left,
    input  logic [CW-1:0]   ld_right,
    input  logic [CW-1:0]   ld_top,
    input  logic [CW-1:0]   ld_bottom,
    input  logic [COLW-1:0] ld_colour,
    input  logic [COLW-1:0] bg_colour,
    input  logic [CW-1:0]   pix_x,
    input  logic [CW-1:0]   pix_y,
    input  logic            pix_de,
    output logic [COLW-1:0] rgb_out,
    output logic            de_out
);
    logic [N-1:0]    hit;
    logic            hit_de;
    logic            win_valid;
    logic [IDXW-1:0] win_idx;
    logic            win_de;

    rr_mask_store #(.N(N), .COLS(COLS), .ROWS(ROWS), .CW(CW)) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_clear),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .ld_left  (ld_left),
        .ld_right (ld_right),
        .ld_top   (ld_top),
        .ld_bottom(ld_bottom),
        .pix_x    (pix_x),
        .pix_y    (pix_y),
        .pix_de   (pix_de),
        .hit      (hit),
        .hit_de   (hit_de)
    );

    rr_pick_tree #(.N(N)) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .de_in    (hit_de),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .de_out   (win_de)
    );

    rr_colour_out #(.N(N), .COLW(COLW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .ld_colour(ld_colour),
        .bg_colour(bg_colour),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .win_de   (win_de),
        .rgb      (rgb_out),
        .de       (de_out)
    );
endmodule

// File: rtl/rect_raster_chk.sv
module rect_raster_chk
    import rr_pkg::*;
#(
    parameter int N      = RR_RECTS,
    parameter int COLW   = RR_COLW,
    localparam int LAT   = rr_latency(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_clear,
    input logic            ld_en,
    input logic [COLW-1:0] bg_colour,
    input logic            pix_de,
    input logic [COLW-1:0] rgb_out,
    input logic            de_out
);
    logic [LAT-1:0] de_hist_q;
    logic [7:0]     since_rst_q;
    logic [7:0]     settle_q;
    logic           empty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            de_hist_q   <= '0;
            since_rst_q <= '0;
            settle_q    <= '0;
            empty_q     <= 1'b1;
        end else begin
            de_hist_q <= {de_hist_q[LAT-2:0], pix_de};
            if (since_rst_q != 8'hFF) since_rst_q <= since_rst_q + 8'd1;
            if (ld_en) begin
                empty_q  <= 1'b0;
                settle_q <= '0;
            end else if (frame_clear) begin
                empty_q  <= 1'b1;
                settle_q <= '0;
            end else if (settle_q != 8'hFF) begin
                settle_q <= settle_q + 8'd1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (rgb_out == '0 && !de_out)); // R1

    AST_EMPTY_SHOWS_BG: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_q && settle_q >= 8'(LAT) && de_out) |-> rgb_out == $past(bg_colour)); // R4

    AST_DE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= 8'(LAT)) |-> de_out == de_hist_q[LAT-1]); // R8

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !de_out |-> rgb_out == '0); // R9
endmodule

bind rect_raster rect_raster_chk #(.N(N), .COLW(COLW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_clear(frame_clear),
    .ld_en      (ld_en),
    .bg_colour  (bg_colour),
    .pix_de     (pix_de),
    .rgb_out    (rgb_out),
    .de_out     (de_out)
);

// File: tb/rect_raster_test.sv
module rect_raster_test;
    localparam int LAT = 8;
    localparam logic [15:0] BG = 16'h0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_clear = 1'b0;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_idx = '0;
    logic [9:0]  ld_left = '0, ld_right = '0, ld_top = '0, ld_bottom = '0;
    logic [15:0] ld_colour = '0;
    logic [15:0] bg_colour = BG;
    logic [9:0]  pix_x = '0, pix_y = '0;
    logic        pix_de = 1'b0;
    logic [15:0] rgb_out;
    logic        de_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rect_raster uut (
        .clk(clk), .rst_n(rst_n), .frame_clear(frame_clear), .ld_en(ld_en),
        .ld_idx(ld_idx), .ld_left(ld_left), .ld_right(ld_right), .ld_top(ld_top),
        .ld_bottom(ld_bottom), .ld_colour(ld_colour), .bg_colour(bg_colour),
        .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de),
        .rgb_out(rgb_out), .de_out(de_out)
    );

    // {x, y, expected colour, requirement number}
    localparam logic [43:0] VEC [15] = '{
        {10'd10,  10'd5,   16'h0303, 8'd2},  // R2 left/top inclusive
        {10'd12,  10'd7,   16'h0303, 8'd2},  // R2 interior
        {10'd20,  10'd5,   BG,       8'd2},  // R2 right exclusive
        {10'd10,  10'd15,  BG,       8'd2},  // R2 bottom exclusive
        {10'd15,  10'd10,  16'h4040, 8'd3},  // R3 overlap of 3 and 40
        {10'd29,  10'd24,  16'h4040, 8'd2},  // R2 last covered corner
        {10'd30,  10'd24,  BG,       8'd4},  // R4 uncovered
        {10'd150, 10'd150, 16'h0A0A, 8'd2},  // R2 rectangle 0
        {10'd50,  10'd200, BG,       8'd5},  // R5 zero width
        {10'd150, 10'd300, BG,       8'd5},  // R5 zero height
        {10'd639, 10'd479, 16'hF63F, 8'd10}, // R10 last pixel
        {10'd600, 10'd470, 16'hF63F, 8'd2},  // R2 corner of 63
        {10'd599, 10'd470, BG,       8'd2},  // R2 just left of 63
        {10'd640, 10'd479, BG,       8'd10}, // R10 x off screen
        {10'd639, 10'd480, BG,       8'd10}  // R10 y off screen
    };

    task automatic check(input bit ok, input int req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [5:0] idx, input int l, input int r,
                        input int t, input int b, input logic [15:0] c,
                        input bit with_clear);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_colour = c;
        ld_left = 10'(l); ld_right = 10'(r); ld_top = 10'(t); ld_bottom = 10'(b);
        frame_clear = with_clear;
        @(negedge clk);
        ld_en = 1'b0; frame_clear = 1'b0;
    endtask

    task automatic pixel(input int x, input int y, input bit de,
                         input logic [15:0] exp, input int req);
        @(negedge clk);
        pix_x = 10'(x); pix_y = 10'(y); pix_de = de;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        check(rgb_out == exp && de_out == de, req, rgb_out, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rgb_out == 16'h0 && de_out == 1'b0, 1, rgb_out, 16'h0);
        rst_n = 1'b1;
        pixel(10, 5, 1'b1, BG, 1); // R1 nothing covers after reset

        load(6'd0,  100, 200, 100, 200, 16'h0A0A, 1'b0);
        load(6'd3,  10,  20,  5,   15,  16'h0303, 1'b0);
        load(6'd40, 15,  30,  10,  25,  16'h4040, 1'b0);
        load(6'd63, 600, 1000, 470, 1000, 16'hF63F, 1'b0);
        load(6'd5,  50,  50,  0,   480, 16'h5555, 1'b0);
        load(6'd6,  0,   640, 300, 300, 16'h6666, 1'b0);

        for (int i = 0; i < 15; i++)
            pixel(int'(VEC[i][43:34]), int'(VEC[i][33:24]), 1'b1,
                  VEC[i][23:8], int'(VEC[i][7:0]));

        // R6 reload of index 40 moves it and changes its colour
        load(6'd40, 200, 210, 200, 210, 16'h4141, 1'b0);
        pixel(15, 10, 1'b1, 16'h0303, 6);
        pixel(205, 205, 1'b1, 16'h4141, 6);

        // R7 clear together with a load of index 7
        load(6'd7, 0, 5, 0, 5, 16'h7777, 1'b1);
        pixel(205, 205, 1'b1, BG, 7);
        pixel(12, 7, 1'b1, BG, 7);
        pixel(2, 2, 1'b1, 16'h7777, 7);

        // R9 blanking forces black
        pixel(2, 2, 1'b0, 16'h0000, 9);

        // R8 exact latency: new pixel appears on the eighth edge, not the seventh
        pixel(2, 2, 1'b1, 16'h7777, 8);
        @(negedge clk);
        pix_x = 10'd100; pix_y = 10'd100;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        check(rgb_out == 16'h7777, 8, rgb_out, 16'h7777);
        @(posedge clk);
        @(negedge clk);
        check(rgb_out == BG, 8, rgb_out, BG);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule